// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a memory-mapped compare-match timer. It holds a 32-bit up-counter, a 32-bit compare value and a 16-bit control/status word. The counter advances on a tick taken from the input clock through a selectable prescaler, and only while an external run input is high. In periodic mode it counts from 0 up to the compare value and starts again from 0. In free-running mode it counts to all-ones and wraps. A hit on the compare value sets a sticky match flag. A request-select field then sends the event to a level interrupt, to a one-cycle DMA request, or to neither.

Software reaches the three registers over a simple synchronous bus with a word index. Register writes do not take effect at once. A write to the control/status word or to the compare value lands a fixed two clocks later. A write to the counter lands three clocks later. While a counter write is pending, a read-only busy bit in the control/status word shows 1, and any further counter write is dropped.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0, the compare value reads all-ones, the control/status word reads 0, and `irq_o` and `dma_req_o` are 0.
- R2: Control/status bit positions: 15 match flag, 14 overflow flag, 13 counter-write busy (read-only), 12 start flag, 11 stop flag, 10 start/stop interrupt enable, 9 compare select, 8 periodic mode, 7 output interrupt enable, 5:4 request select, 3 debug disable, 2:0 clock select. Bit 6 reads 0. Writing 0xFFFF to a cleared word reads back 0x1FBF. Register index 0 is control/status, 1 is the counter, 2 is the compare value, and index 3 reads 0.
- R3: A control/status or compare write sampled at clock edge k is not visible after edge k+1 and is visible after edge k+2.
- R4: A counter write sampled at edge k sets busy (bit 13) from edge k to edge k+3. The new value and busy = 0 are both visible after edge k+3.
- R5: A counter write issued while busy is 1 has no effect.
- R6: Clock select 4, 5, 6 and 7 give one tick every 8, 32, 128 and 1 clocks of running. After N clocks of running from a cleared prescaler, the counter has advanced by floor(N/divider).
- R7: Clock select values 0 to 3 produce no ticks.
- R8: The prescaler is cleared whenever the run input is 0, so every start begins a full prescale period.
- R9: With bit 8 = 1, a tick while the counter equals the compare value returns the counter to 0 and sets the match flag. The period is compare+1 ticks.
- R10: With bit 8 = 0, the counter wraps from all-ones to 0 and sets the overflow flag. A compare hit sets the match flag but does not clear the counter.
- R11: A write of 0 to bit 15 or bit 14 clears that flag. A write of 1 leaves the flag unchanged and never sets it.
- R12: `irq_o` is 1 exactly when the match flag is 1 and request select is 2.
- R13: With request select 1, `dma_req_o` pulses for one cycle after each compare hit. It never pulses with any other request select.
- R14: The counter changes only on a tick or a landed counter write. It holds while the run input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel start bit; counting is allowed while high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the indexed register (combinational) |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | One-cycle DMA request pulse |

## Verification
The bench probes the write pipelines cycle by cycle. It reads a register one edge before and at the edge where a write should land, so a design that applies writes too early or too late shows the old or new value in the wrong cycle. A second counter write is issued while the busy bit is set; a design that accepts it ends with the wrong count. Every clock-select code is swept over two run lengths, and the prescaler is stopped part-way through a period. A mis-mapped code, or a prescaler that keeps its partial count across a stop, gives a count that disagrees with floor(N/divider). The periodic, free-running and request-routing cases expose a counter that fails to clear, an overflow that is missing or fires in the wrong mode, flags that writing 1 can change, and requests routed to the wrong output.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CSR_W  = 16;
    localparam int B_MATCH = 15;
    localparam int B_OVF   = 14;
    localparam int B_BUSY  = 13;
    localparam int B_PER   = 8;
    localparam int RS_LO   = 4;
    localparam int CK_LO   = 0;

    // bits software can store directly (flags, busy and bit 6 excluded)
    localparam logic [CSR_W-1:0] CSR_STORE_MASK = 16'h1FBF;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_sel_e;

    localparam logic [1:0] IDX_CSR = 2'd0;
    localparam logic [1:0] IDX_CNT = 2'd1;
    localparam logic [1:0] IDX_CMP = 2'd2;

    // {valid, log2(divider)} for a clock-select code
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        case (code)
            3'd4:    div_shift = {1'b1, 3'd3};
            3'd5:    div_shift = {1'b1, 3'd5};
            3'd6:    div_shift = {1'b1, 3'd7};
            3'd7:    div_shift = {1'b1, 3'd0};
            default: div_shift = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [2:0] clk_sel_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [PW-1:0] presc;
    } pre_t;

    pre_t p_d, p_q;
    logic [3:0]  sel;
    logic [PW:0] limit;

    always_comb begin
        p_d    = p_q;
        sel    = div_shift(clk_sel_i);
        limit  = ((PW+1)'(1) << sel[2:0]) - (PW+1)'(1);
        tick_o = run_i && sel[3] && ({1'b0, p_q.presc} >= limit);
        if (!run_i || !sel[3] || tick_o) begin
            p_d.presc = '0;
        end else begin
            p_d.presc = p_q.presc + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // R8
    presc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (p_q.presc == '0));

endmodule

// File: rtl/cmt_wr_delay.sv
module cmt_wr_delay #(
    parameter int DW    = 32,
    parameter int LAT   = 2,
    parameter bit BLOCK = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [DW-1:0] data_i,
    output logic          apply_o,
    output logic [DW-1:0] data_o,
    output logic          busy_o
);
    localparam int CNTW = $clog2(LAT + 1);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [DW-1:0]   data;
    } slot_t;

    slot_t s_d, s_q;
    logic  accept;

    always_comb begin
        s_d     = s_q;
        apply_o = s_q.busy && (s_q.cnt == CNTW'(1));
        accept  = req_i && !(BLOCK && s_q.busy);
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNTW'(LAT);
            s_d.data = data_i;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt - CNTW'(1);
            s_d.busy = !apply_o;
        end
    end

    assign data_o = s_q.data;
    assign busy_o = s_q.busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3
    wr_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !busy_o) |=> busy_o);

    // R4
    wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_o && !req_i) |=> !busy_o);

    generate
        if (BLOCK) begin : g_block
            // R5
            wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (busy_o && !apply_o && req_i) |=> (busy_o && $stable(data_o)));
        end
    endgenerate

endmodule

// File: rtl/cmt_core.sv
module cmt_core
    import cmt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             csr_apply_i,
    input  logic [CSR_W-1:0] csr_wdata_i,
    input  logic             cmp_apply_i,
    input  logic [CW-1:0]    cmp_wdata_i,
    input  logic             cnt_apply_i,
    input  logic [CW-1:0]    cnt_wdata_i,
    output logic [CSR_W-1:0] csr_o,
    output logic [CW-1:0]    cnt_o,
    output logic [CW-1:0]    cmp_o,
    output logic             dma_o
);
    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    cmp;
        logic [CSR_W-1:0] csr;
        logic             dma;
    } core_t;

    core_t    c_d, c_q;
    logic     hit;
    logic     wrap;
    logic     periodic;
    req_sel_e rsel;

    always_comb begin
        c_d      = c_q;
        hit      = tick_i && (c_q.cnt == c_q.cmp);
        wrap     = tick_i && (c_q.cnt == '1);
        periodic = c_q.csr[B_PER];
        rsel     = req_sel_e'(c_q.csr[RS_LO +: 2]);

        if (tick_i) begin
            c_d.cnt = (periodic && hit) ? '0 : c_q.cnt + CW'(1);
        end
        if (cnt_apply_i) begin
            c_d.cnt = cnt_wdata_i;
        end
        if (cmp_apply_i) begin
            c_d.cmp = cmp_wdata_i;
        end
        if (csr_apply_i) begin
            c_d.csr          = csr_wdata_i & CSR_STORE_MASK;
            c_d.csr[B_MATCH] = c_q.csr[B_MATCH] & csr_wdata_i[B_MATCH];
            c_d.csr[B_OVF]   = c_q.csr[B_OVF] & csr_wdata_i[B_OVF];
        end
        if (hit) begin
            c_d.csr[B_MATCH] = 1'b1;
        end
        if (wrap && !periodic) begin
            c_d.csr[B_OVF] = 1'b1;
        end
        c_d.dma = hit && (rsel == REQ_DMA);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.cnt <= '0;
            c_q.cmp <= '1;
            c_q.csr <= '0;
            c_q.dma <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign csr_o = c_q.csr;
    assign cnt_o = c_q.cnt;
    assign cmp_o = c_q.cmp;
    assign dma_o = c_q.dma;

    // R9
    period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && periodic && (cnt_o == cmp_o) && !cnt_apply_i) |=> (cnt_o == '0));

    // R14
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !cnt_apply_i) |=> $stable(cnt_o));

    // R10
    ovf_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(csr_o[B_OVF]) |-> (($past(cnt_o) == '1) && !$past(periodic) && $past(tick_i)));

    // R9
    match_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(csr_o[B_MATCH]) |-> $past(tick_i && (cnt_o == cmp_o)));

    // R13
    dma_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_o |-> $past(tick_i && (cnt_o == cmp_o) && (csr_o[RS_LO +: 2] == 2'd1)));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CW      = 32,
    parameter int AW      = 2,
    parameter int REG_LAT = 2,
    parameter int CNT_LAT = 3,
    parameter int PW      = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] rdata_o,
    output logic          irq_o,
    output logic          dma_req_o
);
    logic             csr_req, cmp_req, cnt_req;
    logic             csr_apply, cmp_apply, cnt_apply;
    logic [CSR_W-1:0] csr_pend;
    logic [CW-1:0]    cmp_pend, cnt_pend;
    logic             csr_busy_unused, cmp_busy_unused, cnt_busy;
    logic [CSR_W-1:0] csr_q;
    logic [CW-1:0]    cnt_q, cmp_q;
    logic             tick;
    logic [CSR_W-1:0] csr_view;

    assign csr_req = wr_en_i && (addr_i == AW'(IDX_CSR));
    assign cnt_req = wr_en_i && (addr_i == AW'(IDX_CNT));
    assign cmp_req = wr_en_i && (addr_i == AW'(IDX_CMP));

    cmt_wr_delay #(.DW(CSR_W), .LAT(REG_LAT), .BLOCK(1'b0)) csr_slot_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (csr_req),
        .data_i  (wdata_i[CSR_W-1:0]),
        .apply_o (csr_apply),
        .data_o  (csr_pend),
        .busy_o  (csr_busy_unused)
    );

    cmt_wr_delay #(.DW(CW), .LAT(REG_LAT), .BLOCK(1'b0)) cmp_slot_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (cmp_req),
        .data_i  (wdata_i),
        .apply_o (cmp_apply),
        .data_o  (cmp_pend),
        .busy_o  (cmp_busy_unused)
    );

    cmt_wr_delay #(.DW(CW), .LAT(CNT_LAT), .BLOCK(1'b1)) cnt_slot_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (cnt_req),
        .data_i  (wdata_i),
        .apply_o (cnt_apply),
        .data_o  (cnt_pend),
        .busy_o  (cnt_busy)
    );

    cmt_prescaler #(.PW(PW)) presc_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .clk_sel_i (csr_q[CK_LO +: 3]),
        .tick_o    (tick)
    );

    cmt_core #(.CW(CW)) core_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .csr_apply_i (csr_apply),
        .csr_wdata_i (csr_pend),
        .cmp_apply_i (cmp_apply),
        .cmp_wdata_i (cmp_pend),
        .cnt_apply_i (cnt_apply),
        .cnt_wdata_i (cnt_pend),
        .csr_o       (csr_q),
        .cnt_o       (cnt_q),
        .cmp_o       (cmp_q),
        .dma_o       (dma_req_o)
    );

    always_comb begin
        csr_view         = csr_q;
        csr_view[B_BUSY] = cnt_busy;
        case (addr_i)
            AW'(IDX_CSR): rdata_o = CW'(csr_view);
            AW'(IDX_CNT): rdata_o = cnt_q;
            AW'(IDX_CMP): rdata_o = cmp_q;
            default:      rdata_o = '0;
        endcase
    end

    assign irq_o = csr_q[B_MATCH] && (csr_q[RS_LO +: 2] == REQ_IRQ);

    // R12
    irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !dma_req_o);

endmodule

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        dma;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmt_channel dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .run_i     (run),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .dma_req_o (dma)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        addr  = idx;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        addr = idx;
        #1;
        v = rdata;
    endtask

    task automatic run_for(input int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    function automatic int divider(input int code);
        case (code)
            4: return 8;
            5: return 32;
            6: return 128;
            7: return 1;
            default: return 0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        int dma_seen;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 csr", v, 32'h0);
        rd(2'd1, v); chk("R1 cnt", v, 32'h0);
        rd(2'd2, v); chk("R1 cmp", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 dma", {31'd0, dma}, 32'd0);

        // R2 field storage: flags cannot be set by writing 1, bit 6 and busy read 0
        wr(2'd0, 32'h0000_FFFF); idle(3);
        rd(2'd0, v); chk("R2 csr store mask", v, 32'h0000_1FBF);
        rd(2'd3, v); chk("R2 index3", v, 32'h0);

        // R3 compare write lands at edge k+2
        wr(2'd2, 32'd5);
        rd(2'd2, v); chk("R3 cmp after k", v, 32'hFFFF_FFFF);
        idle(1); rd(2'd2, v); chk("R3 cmp after k+1", v, 32'hFFFF_FFFF);
        idle(1); rd(2'd2, v); chk("R3 cmp after k+2", v, 32'd5);

        // R3 control write lands at edge k+2
        wr(2'd0, 32'h0000_0007);
        idle(1); rd(2'd0, v); chk("R3 csr after k+1", v, 32'h0000_1FBF);
        idle(1); rd(2'd0, v); chk("R3 csr after k+2", v, 32'h0000_0007);

        // R4 R5 counter write delay, busy bit, blocked second write
        wr(2'd1, 32'd100);
        rd(2'd0, v); chk("R4 busy after k", v, 32'h0000_2007);
        rd(2'd1, v); chk("R4 cnt after k", v, 32'd0);
        wr(2'd1, 32'd200);
        rd(2'd1, v); chk("R4 cnt after k+1", v, 32'd0);
        idle(1);
        rd(2'd0, v); chk("R4 busy after k+2", v, 32'h0000_2007);
        idle(1);
        rd(2'd0, v); chk("R4 busy cleared k+3", v, 32'h0000_0007);
        rd(2'd1, v); chk("R4 cnt landed k+3", v, 32'd100);
        idle(3);
        rd(2'd1, v); chk("R5 blocked write ignored", v, 32'd100);

        // R14 hold while stopped, then count at /1
        idle(10);
        rd(2'd1, v); chk("R14 hold while stopped", v, 32'd100);
        run_for(7); idle(1);
        rd(2'd1, v); chk("R14 count at div1", v, 32'd107);

        // R6 R7 sweep every clock-select code
        for (int code = 0; code < 8; code++) begin
            for (int rep = 0; rep < 2; rep++) begin
                int n;
                n = (rep == 0) ? 37 : 300;
                wr(2'd0, 32'(code)); idle(3);
                wr(2'd1, 32'd0); idle(4);
                run_for(n); idle(1);
                rd(2'd1, v);
                if (code >= 4) chk("R6 prescale count", v, 32'(n / divider(code)));
                else           chk("R7 no tick for code", v, 32'd0);
            end
        end

        // R8 partial prescale period discarded on stop
        wr(2'd0, 32'h0000_0004); idle(3);
        wr(2'd1, 32'd0); idle(4);
        run_for(5); idle(2);
        run_for(5); idle(1);
        rd(2'd1, v); chk("R8 partial periods lost", v, 32'd0);
        idle(1);
        run_for(8); idle(1);
        rd(2'd1, v); chk("R8 full period after start", v, 32'd1);

        // R9 R12 periodic mode with interrupt routing (bit8, sel=2 at 5:4, code 7)
        wr(2'd0, 32'h0000_0127); idle(3);
        wr(2'd2, 32'd3); idle(3);
        wr(2'd1, 32'd0); idle(4);
        chk("R12 irq low before hit", {31'd0, irq}, 32'd0);
        dma_seen = 0;
        run = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dma) dma_seen++;
        end
        run = 1'b0;
        idle(1);
        rd(2'd1, v); chk("R9 periodic count", v, 32'd2);
        rd(2'd0, v); chk("R9 match flag set", v, 32'h0000_8127);
        chk("R12 irq high", {31'd0, irq}, 32'd1);
        chk("R13 no dma with sel2", 32'(dma_seen), 32'd0);

        // R11 writing 1 keeps the flag, writing 0 clears it
        wr(2'd0, 32'h0000_8127); idle(3);
        rd(2'd0, v); chk("R11 write1 keeps", v, 32'h0000_8127);
        wr(2'd0, 32'h0000_0127); idle(3);
        rd(2'd0, v); chk("R11 write0 clears", v, 32'h0000_0127);
        chk("R12 irq low after clear", {31'd0, irq}, 32'd0);

        // R13 dma pulses, sel=1, cmp=2, periodic, code 7
        wr(2'd0, 32'h0000_0117); idle(3);
        wr(2'd2, 32'd2); idle(3);
        wr(2'd1, 32'd0); idle(4);
        dma_seen = 0;
        run = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dma) dma_seen++;
        end
        run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (dma) dma_seen++;
        end
        chk("R13 dma pulse count", 32'(dma_seen), 32'd6);
        chk("R12 no irq with sel1", {31'd0, irq}, 32'd0);

        // R10 free-running wrap and overflow; match does not clear
        wr(2'd0, 32'h0000_0007); idle(3);
        wr(2'd2, 32'd5); idle(3);
        wr(2'd1, 32'hFFFF_FFFD); idle(4);
        run_for(10); idle(1);
        rd(2'd1, v); chk("R10 free-run count", v, 32'd7);
        rd(2'd0, v); chk("R10 overflow and match", v, 32'h0000_C007);
        wr(2'd0, 32'h0000_8007); idle(3);
        rd(2'd0, v); chk("R11 overflow cleared only", v, 32'h0000_8007);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule